// File: doc/BRIEF.md
# Accumulator Stack Processor Core

This block is a small multi-cycle processor. It fetches one 16-bit instruction per step from a unified, word-addressed memory. The memory sits outside the block and returns read data one cycle after the address is presented. The processor then executes the instruction. Its state is two operand registers A and B, a result register R, an index register X, a program counter, a stack pointer, an I/O data register, an I/O address register, a zero flag and a halt state.

Arithmetic and compare instructions write their result into R. After every step the zero flag takes the value (R == 0). A compare leaves R = 0 when its condition is true, so "branch on true" means "branch when zero". The stack grows downward from the top memory word and holds both pushed data and return addresses.

Each step walks a fixed state sequence:
- IDLE: halted, waiting for `start`.
- FETCH: presents PC to memory and services the input interrupt.
- DECODE: latches the instruction word and increments PC.
- EXEC: executes the instruction and issues any write or first read.
- READ: consumes the first read data; a read-modify-write also writes back here.
- READ2: consumes a second read; used only by MEMEQ.
- RETIRE: updates the zero flag and pulses `step_done`.

The transitions are:
- IDLE→FETCH on `start`.
- FETCH→DECODE→EXEC unconditionally.
- EXEC→READ for memory-reading opcodes, and EXEC→RETIRE for all others.
- READ→READ2 for MEMEQ, and READ→RETIRE otherwise.
- READ2→RETIRE unconditionally.
- RETIRE→IDLE when the step halted the core, and RETIRE→FETCH otherwise.

Top module: `acc_cpu`

## Requirements
- R1: Instruction word format is opcode in bits 15:10 and a 10-bit operand in bits 9:0. The opcode codes are HALT=0, IMMA=1, IMMB=2, STR=3, STA=4, STB=5, LDA=6, LDB=7, LDX=8, XINC=9, XDEC=10, MOVBX=11, STRX=12, LDAX=13, LDBX=14, PUSH=15, POP=16, CALL=17, RET=18, ADD=19, SUB=20, MUL=21, DIV=22, JMP=23, JMPI=24, CMP=25, MEMEQ=26, MEMZ=27, BRZ=28, BRNZ=29, SKNZ=30, OUT=31, IN=32, INC=33, DEC=34. Compare selectors are eq=0, gt=1, zero=2. INC/DEC selectors are A=0, B=1, X=2.
- R2: After reset the core is halted, the zero flag is 0, `io_addr` and `io_data` are 0, and SP holds the top memory address. A `start` while halted loads PC from `start_addr` when `start_use_addr` is 1, and loads 0 otherwise.
- R3: A step without a memory read takes 4 cycles. A step with one read takes 5 cycles, and MEMEQ takes 6. `step_done` is a one-cycle pulse in the last cycle of every step.
- R4: IMMA and IMMB load A or B with the zero-extended operand. STR, STA and STB store R, A or B at the operand address. LDA and LDB load A or B from the operand address.
- R5: PUSH writes R at memory[SP] and then decrements SP. POP increments SP and then loads A from memory[SP].
- R6: CALL stores the already-incremented PC at memory[SP], decrements SP and jumps to the operand. RET increments SP and loads PC from memory[SP]. Calls may nest.
- R7: ADD, SUB, MUL and DIV compute A op B into R and copy R into A. MUL keeps the low 16 bits. DIV is signed floor division.
- R8: CMP sets R=1 and clears R to 0 when its condition holds: A==B, A>B (signed), or A==0. MEMEQ clears R when memory[A]==memory[B]. MEMZ clears R when memory[A]==0.
- R9: After every step the zero flag equals (R==0). BRZ jumps when the flag is set. BRNZ jumps when it is clear. SKNZ skips the next word when it is clear.
- R10: STRX, LDAX, LDBX and JMPI use the address operand+X. STRX stores R there, LDAX and LDBX load A or B from it, and JMPI loads PC from it.
- R11: XINC loads X from memory[operand] and writes X+1 back. XDEC loads X, decrements it and writes it back. MOVBX copies B into X. INC and DEC add or subtract 1 on the selected register.
- R12: HALT halts the core with PC pointing back at the HALT word. An undefined opcode, or an invalid CMP/INC/DEC selector, halts the core with PC pointing after the word. While halted, `mem_addr` shows PC and no memory write occurs.
- R13: An `irq_in` seen in FETCH loads A from the I/O register and clears `io_addr`. OUT copies R into the I/O register and drives `io_addr` with the operand. IN only drives `io_addr`. `io_wr_en` writes the I/O register from outside.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Leave halt and begin executing |
| start_use_addr | input | 1 | Take PC from start_addr on start, else 0 |
| start_addr | input | 10 | Start address |
| irq_in | input | 1 | Input-interrupt strobe, sampled in FETCH |
| io_wr_en | input | 1 | External write to the I/O data register |
| io_wr_data | input | 16 | Data for the external I/O write |
| mem_addr | output | 10 | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the address |
| io_data | output | 16 | I/O data register |
| io_addr | output | 10 | I/O address register |
| halted | output | 1 | Core is halted |
| zero_flag | output | 1 | Zero flag |
| step_done | output | 1 | Last cycle of a step |

## Verification
A step that starts on the clock edge that samples `start` has its FETCH in the first following cycle. Its `step_done` is therefore due 4, 5 or 6 cycles after that edge, depending on how many memory reads the step needs. Each later step's pulse follows the previous one by the same amount. The zero flag and any register change become visible the cycle after `step_done`. The bench samples every output on the falling clock edge and counts falling edges from the start pulse, so the step cadence is checked exactly. Memory, I/O and address results are compared only after `halted` returns.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int OPC_W = 6;

    typedef enum logic [OPC_W-1:0] {
        OP_HALT  = 6'd0,
        OP_IMMA  = 6'd1,
        OP_IMMB  = 6'd2,
        OP_STR   = 6'd3,
        OP_STA   = 6'd4,
        OP_STB   = 6'd5,
        OP_LDA   = 6'd6,
        OP_LDB   = 6'd7,
        OP_LDX   = 6'd8,
        OP_XINC  = 6'd9,
        OP_XDEC  = 6'd10,
        OP_MOVBX = 6'd11,
        OP_STRX  = 6'd12,
        OP_LDAX  = 6'd13,
        OP_LDBX  = 6'd14,
        OP_PUSH  = 6'd15,
        OP_POP   = 6'd16,
        OP_CALL  = 6'd17,
        OP_RET   = 6'd18,
        OP_ADD   = 6'd19,
        OP_SUB   = 6'd20,
        OP_MUL   = 6'd21,
        OP_DIV   = 6'd22,
        OP_JMP   = 6'd23,
        OP_JMPI  = 6'd24,
        OP_CMP   = 6'd25,
        OP_MEMEQ = 6'd26,
        OP_MEMZ  = 6'd27,
        OP_BRZ   = 6'd28,
        OP_BRNZ  = 6'd29,
        OP_SKNZ  = 6'd30,
        OP_OUT   = 6'd31,
        OP_IN    = 6'd32,
        OP_INC   = 6'd33,
        OP_DEC   = 6'd34
    } opcode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_READ,
        ST_READ2,
        ST_RETIRE
    } state_e;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int W = 16
) (
    input  opcode_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    logic signed [W-1:0] sa, sb, quo, rem;

    always_comb begin
        sa  = $signed(a);
        sb  = $signed(b);
        quo = '0;
        rem = '0;
        if (b != '0) begin
            quo = sa / sb;
            rem = sa % sb;
            // round toward minus infinity when the exact quotient is negative
            if (rem != '0 && (sa[W-1] != sb[W-1])) begin
                quo = quo - 1'b1;
            end
        end
    end

    always_comb begin
        unique case (op)
            OP_SUB:  y = a - b;
            OP_MUL:  y = a * b;
            OP_DIV:  y = quo;
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/acc_cmp.sv
module acc_cmp #(
    parameter int W  = 16,
    parameter int SW = 10
) (
    input  logic [SW-1:0] sel,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic          hit,
    output logic          bad
);

    always_comb begin
        hit = 1'b0;
        bad = 1'b0;
        case (sel)
            SW'(0):  hit = (a == b);
            SW'(1):  hit = ($signed(a) > $signed(b));
            SW'(2):  hit = (a == '0);
            default: bad = 1'b1;
        endcase
    end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic                      start_use_addr,
    input  logic [DATA_W-OPC_W-1:0]   start_addr,
    input  logic                      irq_in,
    input  logic                      io_wr_en,
    input  logic [DATA_W-1:0]         io_wr_data,
    output logic [DATA_W-OPC_W-1:0]   mem_addr,
    output logic                      mem_we,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic [DATA_W-1:0]         io_data,
    output logic [DATA_W-OPC_W-1:0]   io_addr,
    output logic                      halted,
    output logic                      zero_flag,
    output logic                      step_done
);

    localparam int ADDR_W = DATA_W - OPC_W;
    localparam logic [ADDR_W-1:0] SP_TOP = {ADDR_W{1'b1}};

    state_e              state_q, state_d;
    logic [ADDR_W-1:0]   pc_q, sp_q, ioa_q;
    logic [DATA_W-1:0]   a_q, b_q, r_q, x_q, ir_q, tmp_q, io_q;
    logic                zf_q, halt_pend_q;

    opcode_e             op;
    logic [ADDR_W-1:0]   opnd, idx_addr, sp_up;
    logic [DATA_W-1:0]   alu_y, step_val;
    logic                cmp_hit, cmp_bad;

    assign op       = opcode_e'(ir_q[DATA_W-1 -: OPC_W]);
    assign opnd     = ir_q[ADDR_W-1:0];
    assign idx_addr = opnd + x_q[ADDR_W-1:0];
    assign sp_up    = sp_q + 1'b1;
    assign step_val = (op == OP_INC) ? DATA_W'(1) : {DATA_W{1'b1}};

    acc_alu #(.W(DATA_W)) u_alu (
        .op (op),
        .a  (a_q),
        .b  (b_q),
        .y  (alu_y)
    );

    acc_cmp #(.W(DATA_W), .SW(ADDR_W)) u_cmp (
        .sel (opnd),
        .a   (a_q),
        .b   (b_q),
        .hit (cmp_hit),
        .bad (cmp_bad)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and memory port
    always_comb begin
        state_d   = state_q;
        mem_addr  = pc_q;
        mem_we    = 1'b0;
        mem_wdata = r_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_FETCH;
            end
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC;
            ST_EXEC: begin
                state_d = ST_RETIRE;
                case (op)
                    OP_STR:  begin mem_we = 1'b1; mem_addr = opnd; end
                    OP_STA:  begin mem_we = 1'b1; mem_addr = opnd; mem_wdata = a_q; end
                    OP_STB:  begin mem_we = 1'b1; mem_addr = opnd; mem_wdata = b_q; end
                    OP_STRX: begin mem_we = 1'b1; mem_addr = idx_addr; end
                    OP_PUSH: begin mem_we = 1'b1; mem_addr = sp_q; end
                    OP_CALL: begin
                        mem_we    = 1'b1;
                        mem_addr  = sp_q;
                        mem_wdata = {{OPC_W{1'b0}}, pc_q};
                    end
                    OP_LDA, OP_LDB, OP_LDX, OP_XINC, OP_XDEC: begin
                        mem_addr = opnd;
                        state_d  = ST_READ;
                    end
                    OP_LDAX, OP_LDBX, OP_JMPI: begin
                        mem_addr = idx_addr;
                        state_d  = ST_READ;
                    end
                    OP_POP, OP_RET: begin
                        mem_addr = sp_up;
                        state_d  = ST_READ;
                    end
                    OP_MEMEQ, OP_MEMZ: begin
                        mem_addr = a_q[ADDR_W-1:0];
                        state_d  = ST_READ;
                    end
                    default: ;
                endcase
            end
            ST_READ: begin
                state_d = ST_RETIRE;
                case (op)
                    OP_XINC: begin
                        mem_we = 1'b1; mem_addr = opnd; mem_wdata = mem_rdata + 1'b1;
                    end
                    OP_XDEC: begin
                        mem_we = 1'b1; mem_addr = opnd; mem_wdata = mem_rdata - 1'b1;
                    end
                    OP_MEMEQ: begin
                        mem_addr = b_q[ADDR_W-1:0];
                        state_d  = ST_READ2;
                    end
                    default: ;
                endcase
            end
            ST_READ2:  state_d = ST_RETIRE;
            ST_RETIRE: state_d = halt_pend_q ? ST_IDLE : ST_FETCH;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q        <= '0;
            sp_q        <= SP_TOP;
            a_q         <= '0;
            b_q         <= '0;
            r_q         <= '0;
            x_q         <= '0;
            ir_q        <= '0;
            tmp_q       <= '0;
            io_q        <= '0;
            ioa_q       <= '0;
            zf_q        <= 1'b0;
            halt_pend_q <= 1'b0;
        end else begin
            if (io_wr_en) io_q <= io_wr_data;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pc_q        <= start_use_addr ? start_addr : '0;
                        halt_pend_q <= 1'b0;
                    end
                end
                ST_FETCH: begin
                    if (irq_in) begin
                        a_q   <= io_q;
                        ioa_q <= '0;
                    end
                end
                ST_DECODE: begin
                    ir_q <= mem_rdata;
                    pc_q <= pc_q + 1'b1;
                end
                ST_EXEC: begin
                    case (op)
                        OP_HALT: begin
                            halt_pend_q <= 1'b1;
                            pc_q        <= pc_q - 1'b1;
                        end
                        OP_IMMA:  a_q <= {{OPC_W{1'b0}}, opnd};
                        OP_IMMB:  b_q <= {{OPC_W{1'b0}}, opnd};
                        OP_MOVBX: x_q <= b_q;
                        OP_PUSH:  sp_q <= sp_q - 1'b1;
                        OP_CALL: begin
                            sp_q <= sp_q - 1'b1;
                            pc_q <= opnd;
                        end
                        OP_POP, OP_RET: sp_q <= sp_up;
                        OP_ADD, OP_SUB, OP_MUL, OP_DIV: begin
                            r_q <= alu_y;
                            a_q <= alu_y;
                        end
                        OP_JMP: pc_q <= opnd;
                        OP_CMP: begin
                            if (cmp_bad) halt_pend_q <= 1'b1;
                            else         r_q <= cmp_hit ? '0 : DATA_W'(1);
                        end
                        OP_BRZ:  if (zf_q)  pc_q <= opnd;
                        OP_BRNZ: if (!zf_q) pc_q <= opnd;
                        OP_SKNZ: if (!zf_q) pc_q <= pc_q + 1'b1;
                        OP_OUT: begin
                            io_q  <= r_q;
                            ioa_q <= opnd;
                        end
                        OP_IN: ioa_q <= opnd;
                        OP_INC, OP_DEC: begin
                            case (opnd)
                                ADDR_W'(0): a_q <= a_q + step_val;
                                ADDR_W'(1): b_q <= b_q + step_val;
                                ADDR_W'(2): x_q <= x_q + step_val;
                                default:    halt_pend_q <= 1'b1;
                            endcase
                        end
                        OP_STR, OP_STA, OP_STB, OP_STRX, OP_LDA, OP_LDB,
                        OP_LDX, OP_XINC, OP_XDEC, OP_LDAX, OP_LDBX,
                        OP_JMPI, OP_MEMEQ, OP_MEMZ: ;
                        default: halt_pend_q <= 1'b1;
                    endcase
                end
                ST_READ: begin
                    case (op)
                        OP_LDA, OP_LDAX, OP_POP: a_q <= mem_rdata;
                        OP_LDB, OP_LDBX:         b_q <= mem_rdata;
                        OP_LDX, OP_XINC:         x_q <= mem_rdata;
                        OP_XDEC:                 x_q <= mem_rdata - 1'b1;
                        OP_RET, OP_JMPI:         pc_q <= mem_rdata[ADDR_W-1:0];
                        OP_MEMEQ:                tmp_q <= mem_rdata;
                        OP_MEMZ:                 r_q <= (mem_rdata == '0) ? '0 : DATA_W'(1);
                        default: ;
                    endcase
                end
                ST_READ2: begin
                    r_q <= (tmp_q == mem_rdata) ? '0 : DATA_W'(1);
                end
                ST_RETIRE: begin
                    zf_q <= (r_q == '0);
                end
            endcase
        end
    end

    // status outputs
    always_comb begin
        halted    = (state_q == ST_IDLE);
        step_done = (state_q == ST_RETIRE);
        zero_flag = zf_q;
        io_data   = io_q;
        io_addr   = ioa_q;
    end

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         halted,
    input logic         step_done,
    input logic         zero_flag,
    input logic         mem_we,
    input logic [W-1:0] r_val
);

    AST_STEP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> !step_done);  // R3

    AST_ZERO_TRACKS_R: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |=> (zero_flag == (r_val == '0)));  // R9

    AST_ZERO_ONLY_AFTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(zero_flag) |-> $past(step_done));  // R9

    AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !start) |=> halted);  // R12

    AST_NO_WRITE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);  // R12

    AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && start) |=> !halted);  // R2

endmodule

bind acc_cpu acc_cpu_chk #(.W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .halted    (halted),
    .step_done (step_done),
    .zero_flag (zero_flag),
    .mem_we    (mem_we),
    .r_val     (r_q)
);

// File: tb/sim_acc_cpu.sv
module sim_acc_cpu;

    localparam int HALT=0, IMMA=1, IMMB=2, STR=3, STA=4, STB=5, LDA=6, LDB=7,
                   XINC=9, XDEC=10, MOVBX=11, STRX=12, LDAX=13, LDBX=14,
                   PUSH=15, POP=16, CALL=17, RET=18, ADD=19, SUB=20, MUL=21,
                   DIV=22, JMPI=24, CMP=25, MEMEQ=26, MEMZ=27, BRZ=28,
                   BRNZ=29, SKNZ=30, OUT=31, IN=32, INC=33, DEC=34;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        start_use_addr = 1'b0;
    logic [9:0]  start_addr = '0;
    logic        irq_in = 1'b0;
    logic        io_wr_en = 1'b0;
    logic [15:0] io_wr_data = '0;
    logic [9:0]  mem_addr;
    logic        mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;
    logic [15:0] io_data;
    logic [9:0]  io_addr;
    logic        halted, zero_flag, step_done;

    logic [15:0] ram [1024];
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int stamps [32];
    int nst;

    always #2 clk = ~clk;

    acc_cpu u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .start_use_addr(start_use_addr),
        .start_addr(start_addr), .irq_in(irq_in), .io_wr_en(io_wr_en),
        .io_wr_data(io_wr_data), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .io_data(io_data),
        .io_addr(io_addr), .halted(halted), .zero_flag(zero_flag),
        .step_done(step_done)
    );

    always @(posedge clk) begin
        if (mem_we) ram[mem_addr] <= mem_wdata;
        mem_rdata <= ram[mem_addr];
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R3 watchdog actual=%0d expected=<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    function automatic logic [15:0] ins(input int op, input int opnd);
        return {op[5:0], opnd[9:0]};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) ram[i] = '0;
    endtask

    // start the core and wait for halt, recording step_done positions
    task automatic run(input bit use_addr, input int addr, input bit irq_first);
        int n;
        @(negedge clk);
        start = 1'b1;
        start_use_addr = use_addr;
        start_addr = addr[9:0];
        irq_in = irq_first;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        nst = 0;
        while (!halted) begin
            @(negedge clk);
            n++;
            if (n == 2) irq_in = 1'b0;
            if (step_done && nst < 32) begin
                stamps[nst] = n;
                nst++;
            end
        end
    endtask

    task automatic t_reset();
        check("R2 halted after reset", halted, 1);
        check("R2 zero flag after reset", zero_flag, 0);
        check("R2 io_addr after reset", io_addr, 0);
        check("R2 io_data after reset", io_data, 0);
        check("R3 no step_done while halted", step_done, 0);
    endtask

    task automatic t_timing();
        clear_mem();
        ram[100] = ins(IMMA, 5);
        ram[101] = ins(LDA, 200);
        ram[102] = ins(MEMEQ, 0);
        ram[103] = ins(HALT, 0);
        ram[200] = 16'd7;
        run(1'b1, 100, 1'b0);
        check("R3 step count", nst, 4);
        check("R3 R2 first step (start address taken)", stamps[0], 4);
        check("R3 one-read step", stamps[1] - stamps[0], 5);
        check("R3 two-read step", stamps[2] - stamps[1], 6);
        check("R3 plain step", stamps[3] - stamps[2], 4);
        check("R12 PC back on HALT", mem_addr, 103);
    endtask

    task automatic t_stack_call();
        clear_mem();
        ram[0]  = ins(IMMA, 7);
        ram[1]  = ins(IMMB, 3);
        ram[2]  = ins(CALL, 20);
        ram[3]  = ins(STA, 300);
        ram[4]  = ins(PUSH, 0);
        ram[5]  = ins(IMMA, 0);
        ram[6]  = ins(POP, 0);
        ram[7]  = ins(STA, 301);
        ram[8]  = ins(STR, 303);
        ram[9]  = ins(LDA, 310);
        ram[10] = ins(IMMB, 2);
        ram[11] = ins(DIV, 0);
        ram[12] = ins(STA, 302);
        ram[13] = ins(STB, 304);
        ram[14] = ins(IMMB, 4);
        ram[15] = ins(ADD, 0);
        ram[16] = ins(STR, 305);
        ram[17] = ins(HALT, 0);
        ram[20] = ins(SUB, 0);
        ram[21] = ins(CALL, 30);
        ram[22] = ins(RET, 0);
        ram[30] = ins(MUL, 0);
        ram[31] = ins(RET, 0);
        ram[305] = 16'h0055;
        ram[310] = 16'hFFF9;
        run(1'b0, 0, 1'b0);
        check("R6 R7 nested call result", ram[300], 12);
        check("R5 pop into A", ram[301], 12);
        check("R5 push at top address", ram[1023], 12);
        check("R6 nested return address", ram[1022], 22);
        check("R4 store R", ram[303], 12);
        check("R7 floor divide", ram[302], 16'hFFFC);
        check("R4 store B", ram[304], 2);
        check("R7 add to zero", ram[305], 0);
        check("R9 zero flag set by R==0", zero_flag, 1);
        check("R12 halt address", mem_addr, 17);
    endtask

    task automatic t_loop_compare();
        clear_mem();
        ram[0]  = ins(XINC, 350);
        ram[1]  = ins(LDAX, 400);
        ram[2]  = ins(LDB, 351);
        ram[3]  = ins(ADD, 0);
        ram[4]  = ins(STA, 351);
        ram[5]  = ins(LDA, 350);
        ram[6]  = ins(IMMB, 4);
        ram[7]  = ins(CMP, 0);
        ram[8]  = ins(BRNZ, 0);
        ram[9]  = ins(CMP, 1);
        ram[10] = ins(STR, 360);
        ram[11] = ins(IMMA, 5);
        ram[12] = ins(CMP, 1);
        ram[13] = ins(STR, 361);
        ram[14] = ins(IMMA, 0);
        ram[15] = ins(CMP, 2);
        ram[16] = ins(STR, 362);
        ram[17] = ins(BRZ, 19);
        ram[18] = ins(HALT, 0);
        ram[19] = ins(IMMA, 1);
        ram[20] = ins(CMP, 2);
        ram[21] = ins(SKNZ, 0);
        ram[22] = ins(HALT, 0);
        ram[23] = ins(STR, 363);
        ram[24] = ins(LDA, 311);
        ram[25] = ins(IMMB, 1);
        ram[26] = ins(CMP, 1);
        ram[27] = ins(STR, 364);
        ram[28] = ins(IMMA, 400);
        ram[29] = ins(IMMB, 405);
        ram[30] = ins(MEMEQ, 0);
        ram[31] = ins(STR, 365);
        ram[32] = ins(MEMZ, 0);
        ram[33] = ins(STR, 366);
        ram[34] = ins(HALT, 0);
        ram[311] = 16'hFFFF;
        ram[361] = 16'h0055;
        ram[362] = 16'h0055;
        ram[365] = 16'h0055;
        ram[400] = 16'd10;
        ram[401] = 16'd20;
        ram[402] = 16'd30;
        ram[403] = 16'd40;
        ram[405] = 16'd10;
        run(1'b0, 0, 1'b0);
        check("R11 XINC counter write-back", ram[350], 4);
        check("R10 R9 indexed loop sum", ram[351], 100);
        check("R8 gt false on equal", ram[360], 1);
        check("R8 gt true", ram[361], 0);
        check("R8 zero true", ram[362], 0);
        check("R9 BRZ taken and SKNZ skipped", ram[363], 1);
        check("R8 gt is signed", ram[364], 1);
        check("R8 MEMEQ equal", ram[365], 0);
        check("R8 MEMZ nonzero", ram[366], 1);
        check("R12 halt address", mem_addr, 34);
    endtask

    task automatic t_indexed();
        clear_mem();
        ram[0]  = ins(IMMA, 1);
        ram[1]  = ins(CMP, 2);
        ram[2]  = ins(IMMB, 2);
        ram[3]  = ins(MOVBX, 0);
        ram[4]  = ins(STRX, 500);
        ram[5]  = ins(LDBX, 400);
        ram[6]  = ins(STB, 367);
        ram[7]  = ins(XDEC, 352);
        ram[8]  = ins(INC, 2);
        ram[9]  = ins(STRX, 500);
        ram[10] = ins(IMMA, 400);
        ram[11] = ins(INC, 0);
        ram[12] = ins(STA, 368);
        ram[13] = ins(DEC, 1);
        ram[14] = ins(STB, 369);
        ram[15] = ins(JMPI, 520);
        ram[16] = ins(HALT, 0);
        ram[50] = ins(HALT, 0);
        ram[352] = 16'd9;
        ram[402] = 16'd30;
        ram[529] = 16'd50;
        run(1'b0, 0, 1'b0);
        check("R10 R11 store via MOVBX index", ram[502], 1);
        check("R10 indexed load B", ram[367], 30);
        check("R11 XDEC write-back", ram[352], 8);
        check("R11 INC X then indexed store", ram[509], 1);
        check("R11 INC A", ram[368], 401);
        check("R11 DEC B", ram[369], 29);
        check("R10 JMPI target", mem_addr, 50);
    endtask

    task automatic t_io();
        @(negedge clk);
        io_wr_en = 1'b1;
        io_wr_data = 16'h1234;
        @(negedge clk);
        io_wr_en = 1'b0;
        check("R13 external I/O write", io_data, 16'h1234);
        clear_mem();
        ram[0] = ins(IN, 77);
        ram[1] = ins(STA, 600);
        ram[2] = ins(HALT, 0);
        run(1'b0, 0, 1'b1);
        check("R13 interrupt loads A", ram[600], 16'h1234);
        check("R13 IN drives io_addr", io_addr, 77);
        clear_mem();
        ram[0] = ins(IMMA, 5);
        ram[1] = ins(IMMB, 6);
        ram[2] = ins(ADD, 0);
        ram[3] = ins(OUT, 33);
        ram[4] = ins(HALT, 0);
        run(1'b0, 0, 1'b0);
        check("R13 OUT data", io_data, 11);
        check("R13 OUT address", io_addr, 33);
        clear_mem();
        ram[0] = ins(HALT, 0);
        run(1'b0, 0, 1'b1);
        check("R13 interrupt clears io_addr", io_addr, 0);
        check("R13 io_data kept", io_data, 11);
    endtask

    task automatic t_fatal();
        clear_mem();
        ram[0] = ins(63, 0);
        run(1'b0, 0, 1'b0);
        check("R12 undefined opcode halts", halted, 1);
        check("R12 undefined opcode PC", mem_addr, 1);
        check("R12 one step only", nst, 1);
        clear_mem();
        ram[0] = ins(IMMA, 3);
        ram[1] = ins(INC, 3);
        ram[2] = ins(IMMA, 1);
        run(1'b0, 0, 1'b0);
        check("R12 bad INC selector PC", mem_addr, 2);
        clear_mem();
        ram[0] = ins(CMP, 3);
        ram[1] = ins(IMMA, 1);
        run(1'b0, 0, 1'b0);
        check("R12 bad CMP selector PC", mem_addr, 1);
        check("R1 R12 no step after fatal", nst, 1);
    endtask

    initial begin
        clear_mem();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_stack_call();
        t_loop_compare();
        t_indexed();
        t_io();
        t_fatal();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule